// File: doc/BRIEF.md
# Two-Wire Command and Status Target

This block is the bus-facing front end of a record/playback controller. It watches a two-wire serial bus (SCL clock, SDA data, both open-drain) through its system clock and answers only when the controller addresses it by its configured 7-bit device address. A write transaction delivers exactly three payload bytes. The first is a command byte, then the upper half of a 16-bit address, then the lower half. Once the last of them has been acknowledged, the block hands the command and address to the core together with a one-cycle strobe.

A read transaction carries no command byte. Right after the address byte with the read direction bit, the block returns the core's status byte, most significant bit first. It keeps returning a fresh status byte for as long as the controller acknowledges. A not-acknowledge ends the stream.

A transaction that is cut short by a stop or by a repeated start produces no strobe. Repeated starts are accepted at any point.

Top module: `i2c_cmd_target`

## Requirements
- R1: After reset, sdaOe is 0, cmdValid is 0, cmdOut is 0 and addrOut is 0.
- R2: A start (SDA falling while SCL is high) followed by an address byte sent MSB first, whose upper seven bits equal DEV_ADDR, is acknowledged: the block holds SDA low during the ninth SCL high phase. The lowest bit of that byte selects the direction: 0 means write, 1 means read. A stop (SDA rising while SCL is high) returns the block to idle.
- R3: An address byte whose upper seven bits differ from DEV_ADDR is not acknowledged. The block then never pulls SDA low until the next start or stop, whatever the direction bit.
- R4: In a write transaction, the command byte, the high address byte and the low address byte are each acknowledged. The block then presents cmdOut equal to the command byte and addrOut equal to {high byte, low byte}.
- R5: cmdValid is high for exactly one system clock per completed write, after the ninth clock of the low address byte ends. cmdOut and addrOut change only in that cycle.
- R6: Bytes written after the low address byte are not acknowledged and produce no further cmdValid pulse.
- R7: A write cut short by a stop or a repeated start before the low address byte is acknowledged produces no cmdValid pulse and leaves cmdOut and addrOut unchanged.
- R8: A repeated start in any state returns the block to address reception, so a complete transaction may follow with no stop in between.
- R9: In a read, each byte the block returns equals the value of statusIn sampled at the SCL falling edge that ends the previous acknowledge. The data goes out MSB first.
- R10: A not-acknowledge from the controller after a read byte ends the stream: SDA stays released until the next start or stop.
- R11: The block's SDA drive (sdaOe) changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock pin level |
| sdaIn | input | 1 | Bus data pin level |
| sdaOe | output | 1 | When 1, pull the SDA pin low (open-drain) |
| statusIn | input | 8 | Status byte from the core, returned on reads |
| cmdOut | output | 8 | Last committed command byte |
| addrOut | output | 16 | Last committed address, high byte first |
| cmdValid | output | 1 | One-cycle strobe when cmdOut/addrOut update |

## Verification
The bench builds the block with DEV_ADDR set to 7'h2D and a three-stage synchronizer instead of the default two. The odd address, whose lowest bit is 1, makes a near-miss address that differs only in its last bit a real test of the compare. The deeper synchronizer stretches the delay from SCL edge to SDA drive, so the bench also shows that acknowledge and read data still settle inside the SCL low phase at that latency. A reference model of the expected outputs is updated on every committed write and compared with the outputs on every clock, so any stray strobe or output change during aborted, mismatched or read transactions is caught.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int DEVA_W = 7;
  localparam int FRAME_BYTES = 3;

  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftTx;
    logic saveCmd;
    logic saveHi;
    logic commit;
  } dpStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WRX, S_ACK, S_TX, S_MACK, S_SKIP
  } busState_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2ct_dp.sv
module i2ct_dp
  import i2ct_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic                sdaS,
  input  logic [BYTE_W-1:0]   statusIn,
  output logic [BYTE_W-1:0]   rxByte,
  output logic                txMsb,
  output logic [BYTE_W-1:0]   cmdOut,
  output logic [2*BYTE_W-1:0] addrOut,
  output logic                cmdValid
);
  logic [BYTE_W-1:0] txReg;
  logic [BYTE_W-1:0] cmdBuf;
  logic [BYTE_W-1:0] hiBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      txReg    <= '1;
      cmdBuf   <= '0;
      hiBuf    <= '0;
      cmdOut   <= '0;
      addrOut  <= '0;
      cmdValid <= 1'b0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (strb.loadTx)       txReg <= statusIn;
      else if (strb.shiftTx) txReg <= {txReg[BYTE_W-2:0], 1'b1};
      if (strb.saveCmd) cmdBuf <= rxByte;
      if (strb.saveHi)  hiBuf  <= rxByte;
      if (strb.commit) begin
        cmdOut  <= cmdBuf;
        addrOut <= {hiBuf, rxByte};
      end
      cmdValid <= strb.commit;
    end
  end

  assign txMsb = txReg[BYTE_W-1];

  // R5: the strobe never lasts two cycles
  p_pulse_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R5: outputs hold whenever there is no strobe
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> $stable({cmdOut, addrOut}));
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter logic [DEVA_W-1:0] DEV_ADDR = 7'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txMsb,
  output dpStrobe_t         strb,
  output logic              sdaOe
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  localparam int IDX_W = $clog2(FRAME_BYTES);
  localparam logic [IDX_W-1:0] LOW_IDX = IDX_W'(FRAME_BYTES - 1);

  busState_t state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic [IDX_W-1:0] byteIdx, nIdx;
  logic isRead, nRead, addrPhase, nAddrPh, mAck, nMAck;
  logic sclP, sdaP;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclP <= 1'b1;
      sdaP <= 1'b1;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  always_comb begin
    nState  = state;
    nCnt    = cnt;
    nIdx    = byteIdx;
    nRead   = isRead;
    nAddrPh = addrPhase;
    nMAck   = mAck;
    strb    = '0;
    if (startDet) begin
      nState = S_ADDR;
      nCnt   = '0;
    end else if (stopDet) begin
      nState = S_IDLE;
    end else begin
      case (state)
        S_ADDR, S_WRX: begin
          if (sclRise && cnt != FULL) begin
            strb.shiftIn = 1'b1;
            nCnt = cnt + 1'b1;
          end else if (sclFall && cnt == FULL) begin
            nCnt = '0;
            if (state == S_ADDR) begin
              if (rxByte[BYTE_W-1 -: DEVA_W] == DEV_ADDR) begin
                nState  = S_ACK;
                nRead   = rxByte[0];
                nAddrPh = 1'b1;
              end else begin
                nState = S_SKIP;
              end
            end else begin
              nState       = S_ACK;
              nAddrPh      = 1'b0;
              strb.saveCmd = (byteIdx == '0);
              strb.saveHi  = (byteIdx == IDX_W'(1));
            end
          end
        end
        S_ACK: begin
          if (sclFall) begin
            if (addrPhase) begin
              if (isRead) begin
                strb.loadTx = 1'b1;
                nState = S_TX;
              end else begin
                nState = S_WRX;
                nIdx   = '0;
              end
            end else if (byteIdx == LOW_IDX) begin
              strb.commit = 1'b1;
              nState = S_SKIP;
            end else begin
              nIdx   = byteIdx + 1'b1;
              nState = S_WRX;
            end
          end
        end
        S_TX: begin
          if (sclFall) begin
            strb.shiftTx = 1'b1;
            if (cnt == LAST) begin
              nCnt   = '0;
              nState = S_MACK;
            end else begin
              nCnt = cnt + 1'b1;
            end
          end
        end
        S_MACK: begin
          if (sclRise) nMAck = ~sdaS;
          else if (sclFall) begin
            if (mAck) begin
              strb.loadTx = 1'b1;
              nState = S_TX;
            end else begin
              nState = S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      byteIdx   <= '0;
      isRead    <= 1'b0;
      addrPhase <= 1'b0;
      mAck      <= 1'b0;
    end else begin
      state     <= nState;
      cnt       <= nCnt;
      byteIdx   <= nIdx;
      isRead    <= nRead;
      addrPhase <= nAddrPh;
      mAck      <= nMAck;
    end
  end

  assign sdaOe = (state == S_ACK) | ((state == S_TX) & ~txMsb);

  // R8: a start always restarts address reception
  p_start_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == S_ADDR && cnt == '0));

  // R2: a stop always returns to idle
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> state == S_IDLE);

  // R9: data is only sent in a read transaction
  p_tx_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX || state == S_MACK) |-> isRead);

  // R4: the bit counter never passes a full byte
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL);
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2ct_pkg::*;
#(
  parameter logic [DEVA_W-1:0] DEV_ADDR    = 7'h48,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaOe,
  input  logic [BYTE_W-1:0]   statusIn,
  output logic [BYTE_W-1:0]   cmdOut,
  output logic [2*BYTE_W-1:0] addrOut,
  output logic                cmdValid
);
  logic sclS, sdaS, txMsb;
  logic [BYTE_W-1:0] rxByte;
  dpStrobe_t strb;

  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclS));
  i2ct_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaS));

  i2ct_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sdaS(sdaS),
    .rxByte(rxByte), .txMsb(txMsb), .strb(strb), .sdaOe(sdaOe));

  i2ct_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaS(sdaS),
    .statusIn(statusIn), .rxByte(rxByte), .txMsb(txMsb),
    .cmdOut(cmdOut), .addrOut(addrOut), .cmdValid(cmdValid));
endmodule

// File: tb/sim_i2c_cmd_target.sv
`timescale 1ns/1ps
module sim_i2c_cmd_target;
  localparam logic [6:0] DEVA = 7'h2D;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic [7:0] statusIn = 8'h00;
  logic sdaOe, cmdValid;
  logic [7:0] cmdOut;
  logic [15:0] addrOut;
  wire sdaBus = sdaM & ~sdaOe;

  i2c_cmd_target #(.DEV_ADDR(DEVA), .SYNC_STAGES(3)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .statusIn(statusIn), .cmdOut(cmdOut), .addrOut(addrOut), .cmdValid(cmdValid));

  int errs = 0, checks = 0, pulses = 0;
  logic [7:0] curCmd = 8'h00, pendCmd = 8'h00;
  logic [15:0] curAddr = 16'h0000, pendAddr = 16'h0000;
  logic prevValid = 1'b0, sclPrev = 1'b1, oePrev = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (cmdValid) begin
        pulses++;
        chk(!prevValid, "R5 single-cycle strobe", 32'(prevValid), 0);
        chk(cmdOut == pendCmd && addrOut == pendAddr, "R4 committed values",
            {8'h0, cmdOut, addrOut}, {8'h0, pendCmd, pendAddr});
        curCmd = pendCmd;
        curAddr = pendAddr;
      end else begin
        chk(cmdOut == curCmd && addrOut == curAddr, "R5 outputs hold",
            {8'h0, cmdOut, addrOut}, {8'h0, curCmd, curAddr});
      end
      chk(!(sclM && sclPrev && sdaOe != oePrev), "R11 sda drive changes with scl low",
          32'(sdaOe), 32'(oePrev));
      prevValid = cmdValid;
      sclPrev = sclM;
      oePrev = sdaOe;
    end
  end

  task automatic q();
    repeat (8) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; q(); sclM = 1'b1; q(); sdaM = 1'b0; q(); sclM = 1'b0; q();
  endtask

  task automatic stopC();
    sdaM = 1'b0; q(); sclM = 1'b1; q(); sdaM = 1'b1; q();
  endtask

  task automatic writeBit(input bit b);
    sdaM = b; q(); sclM = 1'b1; q(); q(); sclM = 1'b0; q();
  endtask

  task automatic readBit(output bit b);
    sdaM = 1'b1; q(); sclM = 1'b1; q(); b = sdaBus; q(); sclM = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    bit r;
    for (int i = 7; i >= 0; i--) writeBit(d[i]);
    readBit(r);
    acked = !r;
  endtask

  task automatic recvByte(output logic [7:0] d, input bit mack, input logic [7:0] nextStatus);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      readBit(r);
      d[i] = r;
    end
    statusIn = nextStatus;
    writeBit(!mack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] d;
    int p0;
    repeat (4) @(negedge clk);
    chk(sdaOe == 1'b0 && cmdValid == 1'b0, "R1 reset outputs", {sdaOe, cmdValid}, 0);
    chk(cmdOut == 8'h00 && addrOut == 16'h0000, "R1 reset values", {cmdOut, addrOut}, 0);
    rstN = 1'b1;
    q();

    // R2 R4: plain write
    pendCmd = 8'hA5; pendAddr = 16'h1234; p0 = pulses;
    startC();
    sendByte({DEVA, 1'b0}, a); chk(a, "R2 address ack", 32'(a), 1);
    sendByte(8'hA5, a); chk(a, "R4 command ack", 32'(a), 1);
    sendByte(8'h12, a); chk(a, "R4 high ack", 32'(a), 1);
    sendByte(8'h34, a); chk(a, "R4 low ack", 32'(a), 1);
    stopC();
    chk(pulses == p0 + 1, "R5 one strobe per write", pulses - p0, 1);
    chk(cmdOut == 8'hA5 && addrOut == 16'h1234, "R4 outputs", {cmdOut, addrOut}, 32'hA51234);

    // R6: extreme values plus a trailing byte
    pendCmd = 8'h00; pendAddr = 16'hFFFF; p0 = pulses;
    startC();
    sendByte({DEVA, 1'b0}, a);
    sendByte(8'h00, a);
    sendByte(8'hFF, a);
    sendByte(8'hFF, a); chk(a, "R4 low ack second frame", 32'(a), 1);
    sendByte(8'h77, a); chk(!a, "R6 extra byte not acked", 32'(a), 0);
    stopC();
    chk(pulses == p0 + 1, "R6 no second strobe", pulses - p0, 1);

    // R3: near-miss address, write then read direction
    pendCmd = 8'hEE; pendAddr = 16'hEEEE; p0 = pulses;
    startC();
    sendByte({DEVA ^ 7'h01, 1'b0}, a); chk(!a, "R3 mismatch write no ack", 32'(a), 0);
    sendByte(8'h11, a); chk(!a, "R3 ignored data", 32'(a), 0);
    sendByte(8'h22, a);
    sendByte(8'h33, a);
    stopC();
    statusIn = 8'h00;
    startC();
    sendByte({DEVA ^ 7'h40, 1'b1}, a); chk(!a, "R3 mismatch read no ack", 32'(a), 0);
    recvByte(d, 1'b1, 8'h00); chk(d == 8'hFF, "R3 bus released", d, 8'hFF);
    stopC();
    chk(pulses == p0, "R3 no strobe", pulses - p0, 0);

    // R7: stop after high byte
    p0 = pulses;
    startC();
    sendByte({DEVA, 1'b0}, a);
    sendByte(8'h5C, a);
    sendByte(8'h99, a);
    stopC();
    chk(pulses == p0 && cmdOut == 8'h00 && addrOut == 16'hFFFF, "R7 stop abort",
        {cmdOut, addrOut}, 32'h00FFFF);

    // R7 R8: repeated start after command byte, then full frame
    startC();
    sendByte({DEVA, 1'b0}, a);
    sendByte(8'h42, a);
    chk(pulses == p0, "R7 restart abort no strobe", pulses - p0, 0);
    pendCmd = 8'h3C; pendAddr = 16'hBEEF;
    startC();
    sendByte({DEVA, 1'b0}, a); chk(a, "R8 address after repeated start", 32'(a), 1);
    sendByte(8'h3C, a);
    sendByte(8'hBE, a);
    sendByte(8'hEF, a);
    stopC();
    chk(pulses == p0 + 1 && cmdOut == 8'h3C && addrOut == 16'hBEEF, "R8 frame after restart",
        {cmdOut, addrOut}, 32'h3CBEEF);

    // R9 R10: status stream
    p0 = pulses;
    statusIn = 8'h96;
    startC();
    sendByte({DEVA, 1'b1}, a); chk(a, "R2 read address ack", 32'(a), 1);
    statusIn = 8'h00;
    recvByte(d, 1'b1, 8'h3B); chk(d == 8'h96, "R9 first status", d, 8'h96);
    recvByte(d, 1'b1, 8'hC4); chk(d == 8'h3B, "R9 second status", d, 8'h3B);
    recvByte(d, 1'b0, 8'h00); chk(d == 8'hC4, "R9 third status", d, 8'hC4);
    recvByte(d, 1'b0, 8'h00); chk(d == 8'hFF, "R10 released after nack", d, 8'hFF);
    stopC();
    chk(pulses == p0, "R9 read gives no strobe", pulses - p0, 0);

    q();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule